// File: doc/BRIEF.md
# Registered Fixed-Point Multiplier with Format Control

This block multiplies two 16-bit operands into a 32-bit double-precision product. Operands, a round request and the two product halves all sit in registers on one rising-edge clock. Each register group has its own load enable, so a datapath can stage operands early, hold a result while new operands arrive, or run a new product every cycle. Each operand carries its own mode bit, which makes it unsigned or two's complement. This allows signed-by-signed, unsigned-by-unsigned and mixed products.

The product can be delivered as is, or shifted left one place with the sign repeated in the top bit of the lower half. The shifted form suits fractional two's complement data. A registered round request adds one at the most significant bit of the lower half, and that bit position follows the format setting. A flow-through control bypasses the product registers. A selector picks which half appears on the upper output port. Each port has an active-low enable, which comes out as an active-high drive flag next to the port data.

Top module: `mulfmt_top`

## Requirements
- R1: On a rising clock edge, the X operand register (value and its mode bit) loads only when `x_load` is 1, and the Y operand register loads only when `y_load` is 1. Otherwise each holds its value.
- R2: The round register captures `round_in` on any rising edge where `x_load` or `y_load` is 1, and holds it otherwise.
- R3: Both product halves load together on a rising edge where `prod_load` is 1. While `prod_load` is 0, the registered outputs do not change.
- R4: A mode bit of 0 treats its operand as unsigned, and 1 treats it as two's complement. All four combinations give the exact product modulo 2^32.
- R5: With `fmt_full` = 1, the upper half is product bits 31:16 and the lower half is bits 15:0.
- R6: With `fmt_full` = 0, the upper half is product bits 30:15 and the lower half is {bit 31, bits 14:0}.
- R7: With the registered round bit at 1, one is added to product bit 15 when `fmt_full` = 1, or to bit 14 when `fmt_full` = 0, before formatting. Carries reach the upper half.
- R8: With `bypass` = 1, the outputs show the formatted product of the current operand registers at once, without a product register stage.
- R9: `lo_data` always carries the lower half. `hi_data` carries the upper half when `upper_sel` = 0 and the lower half when `upper_sel` = 1.
- R10: `lo_drive` is 1 exactly when `lo_oe_n` is 0, and `hi_drive` is 1 exactly when `hi_oe_n` is 0.
- R11: With both operands in two's complement, 0x8000 times 0x8000 with `fmt_full` = 0 gives upper 0x8000 and lower 0x0000. This is the wrapped value, not a saturated one.
- R12: Synchronous active-high `rst` clears the operand, mode, round and product registers, so the registered outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| x_signed | input | 1 | X mode: 1 two's complement, 0 unsigned |
| y_signed | input | 1 | Y mode: 1 two's complement, 0 unsigned |
| round_in | input | 1 | Round request, registered |
| x_load | input | 1 | X register load enable (also round) |
| y_load | input | 1 | Y register load enable (also round) |
| prod_load | input | 1 | Load enable for both product halves |
| fmt_full | input | 1 | 1 full product, 0 shift-left with sign copy |
| bypass | input | 1 | 1 bypasses the product registers |
| upper_sel | input | 1 | 0 upper half, 1 lower half on hi_data |
| lo_oe_n | input | 1 | Active-low enable for the lower port |
| hi_oe_n | input | 1 | Active-low enable for the upper port |
| lo_data | output | 16 | Lower half of the product |
| lo_drive | output | 1 | Lower port is driven |
| hi_data | output | 16 | Upper port data |
| hi_drive | output | 1 | Upper port is driven |

## Verification
The hardest states to reach are those where the registers fall out of step. Examples are a product held while fresh operands already sit in the input registers, a round bit captured by an edge that loaded only one operand, and a stalled X paired with a new Y. The bench reaches them by driving the load enables one at a time in directed sequences. It keeps its own copy of each register's expected content, so the expected product always uses the operand values actually captured. Random rounds then mix all mode, format, round and bypass settings. Directed cases add the most-negative-squared wrap and carries from rounding into the upper half.

// File: rtl/mulfmt_pkg.sv
package mulfmt_pkg;
  typedef enum logic {
    SEL_UPPER_HALF = 1'b0,
    SEL_LOWER_HALF = 1'b1
  } half_sel_e;

  typedef enum logic {
    FMT_SHIFTED = 1'b0,
    FMT_FULL    = 1'b1
  } fmt_e;
endpackage

// File: rtl/mulfmt_opreg.sv
module mulfmt_opreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         mode_d,
  output logic [W-1:0] q,
  output logic         mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      q      <= d;
      mode_q <= mode_d;
    end
  end

  // R1: idle register keeps value and mode
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(q) && $stable(mode_q)));
  // R1: a load captures the presented operand
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d) && mode_q == $past(mode_d)));
endmodule

// File: rtl/mulfmt_core.sv
module mulfmt_core
  import mulfmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         x_is_signed,
  input  logic         y_is_signed,
  input  logic         rnd,
  input  logic         fmt_full,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int PW = 2 * W;

  logic [PW-1:0] x_ext, y_ext, raw, rnd_vec, sum;
  fmt_e          fmt;

  always_comb begin
    x_ext = {{(PW-W){x_is_signed & x[W-1]}}, x};
    y_ext = {{(PW-W){y_is_signed & y[W-1]}}, y};
  end

  assign raw = x_ext * y_ext;
  assign fmt = fmt_e'(fmt_full);

  always_comb begin
    rnd_vec = '0;
    if (rnd) begin
      if (fmt == FMT_FULL) rnd_vec[W-1] = 1'b1;
      else                 rnd_vec[W-2] = 1'b1;
    end
  end

  assign sum = raw + rnd_vec;

  always_comb begin
    if (fmt == FMT_FULL) begin
      hi = sum[PW-1:W];
      lo = sum[W-1:0];
    end else begin
      hi = sum[PW-2:W-1];
      lo = {sum[PW-1], sum[W-2:0]};
    end
  end
endmodule

// File: rtl/mulfmt_preg.sv
module mulfmt_preg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] lo_d,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R3: both halves hold while not loaded
  a_r3_product_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(hi_q) && $stable(lo_q)));
  // R12: reset leaves the product registers at zero
  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (hi_q == '0 && lo_q == '0));
endmodule

// File: rtl/mulfmt_top.sv
module mulfmt_top
  import mulfmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         x_signed,
  input  logic         y_signed,
  input  logic         round_in,
  input  logic         x_load,
  input  logic         y_load,
  input  logic         prod_load,
  input  logic         fmt_full,
  input  logic         bypass,
  input  logic         upper_sel,
  input  logic         lo_oe_n,
  input  logic         hi_oe_n,
  output logic [W-1:0] lo_data,
  output logic         lo_drive,
  output logic [W-1:0] hi_data,
  output logic         hi_drive
);
  logic [W-1:0] x_q, y_q, core_hi, core_lo, reg_hi, reg_lo, sel_hi, sel_lo;
  logic         xs_q, ys_q, rnd_q;
  half_sel_e    half_sel;

  mulfmt_opreg #(.W(W)) u_xreg (
    .clk(clk), .rst(rst), .load(x_load), .d(x_in), .mode_d(x_signed),
    .q(x_q), .mode_q(xs_q)
  );

  mulfmt_opreg #(.W(W)) u_yreg (
    .clk(clk), .rst(rst), .load(y_load), .d(y_in), .mode_d(y_signed),
    .q(y_q), .mode_q(ys_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                  rnd_q <= 1'b0;
    else if (x_load | y_load) rnd_q <= round_in;
  end

  // R2: round bit holds when neither operand register loads
  a_r2_round_hold: assert property (@(posedge clk) disable iff (rst)
    !(x_load | y_load) |=> $stable(rnd_q));

  mulfmt_core #(.W(W)) u_core (
    .x(x_q), .y(y_q), .x_is_signed(xs_q), .y_is_signed(ys_q),
    .rnd(rnd_q), .fmt_full(fmt_full), .hi(core_hi), .lo(core_lo)
  );

  mulfmt_preg #(.W(W)) u_preg (
    .clk(clk), .rst(rst), .load(prod_load), .hi_d(core_hi), .lo_d(core_lo),
    .hi_q(reg_hi), .lo_q(reg_lo)
  );

  assign sel_hi   = bypass ? core_hi : reg_hi;
  assign sel_lo   = bypass ? core_lo : reg_lo;
  assign half_sel = half_sel_e'(upper_sel);

  assign lo_data  = sel_lo;
  assign hi_data  = (half_sel == SEL_LOWER_HALF) ? sel_lo : sel_hi;
  assign lo_drive = ~lo_oe_n;
  assign hi_drive = ~hi_oe_n;

  // R9: with the lower half selected both ports carry the same data
  a_r9_port_mirror: assert property (@(posedge clk) disable iff (rst)
    upper_sel |-> (hi_data == lo_data));
  // R8: in flow-through the lower port follows the arithmetic directly
  a_r8_flow_through: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (lo_data == core_lo));
endmodule

// File: tb/mulfmt_top_tb.sv
module mulfmt_top_tb;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] x_in, y_in;
  logic         x_signed, y_signed, round_in, x_load, y_load, prod_load;
  logic         fmt_full, bypass, upper_sel, lo_oe_n, hi_oe_n;
  logic [W-1:0] lo_data, hi_data;
  logic         lo_drive, hi_drive;

  int tests = 0;
  int fails = 0;

  // bench copy of the captured register state
  logic [W-1:0] m_x, m_y;
  logic         m_xs, m_ys, m_r;
  logic [W-1:0] m_phi, m_plo;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulfmt_top #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .x_signed(x_signed),
    .y_signed(y_signed), .round_in(round_in), .x_load(x_load), .y_load(y_load),
    .prod_load(prod_load), .fmt_full(fmt_full), .bypass(bypass),
    .upper_sel(upper_sel), .lo_oe_n(lo_oe_n), .hi_oe_n(hi_oe_n),
    .lo_data(lo_data), .lo_drive(lo_drive), .hi_data(hi_data), .hi_drive(hi_drive)
  );

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic as, input logic bs,
                                              input logic r, input logic full);
    longint       av, bv, p;
    logic [31:0]  s;
    av = as ? longint'($signed(a)) : longint'(a);
    bv = bs ? longint'($signed(b)) : longint'(b);
    p  = av * bv;
    if (r) p = p + (full ? 64'sd32768 : 64'sd16384);
    s = p[31:0];
    if (full) return s;
    return {s[30:15], s[31], s[14:0]};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act_hi, input logic [W-1:0] act_lo,
                       input logic [W-1:0] exp_hi, input logic [W-1:0] exp_lo);
    tests++;
    if (act_hi !== exp_hi || act_lo !== exp_lo) begin
      fails++;
      $display("FAIL %s: actual %h_%h expected %h_%h", req, act_hi, act_lo, exp_hi, exp_lo);
    end
  endtask

  task automatic idle();
    x_load = 0; y_load = 0; prod_load = 0;
  endtask

  // present operands on a negedge and let one rising edge capture them
  task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b, input logic as,
                          input logic bs, input logic r, input logic lx, input logic ly);
    @(negedge clk);
    x_in = a; y_in = b; x_signed = as; y_signed = bs; round_in = r;
    x_load = lx; y_load = ly; prod_load = 0;
    @(negedge clk);
    if (lx) begin m_x = a; m_xs = as; end
    if (ly) begin m_y = b; m_ys = bs; end
    if (lx | ly) m_r = r;
    idle();
  endtask

  task automatic cap_prod();
    logic [2*W-1:0] e;
    prod_load = 1;
    @(negedge clk);
    prod_load = 0;
    e = ref_prod(m_x, m_y, m_xs, m_ys, m_r, fmt_full);
    m_phi = e[2*W-1:W]; m_plo = e[W-1:0];
  endtask

  task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic as, input logic bs, input logic r, input logic full);
    fmt_full = full; bypass = 0; upper_sel = 0;
    load_ops(a, b, as, bs, r, 1, 1);
    cap_prod();
    check(req, hi_data, lo_data, m_phi, m_plo);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2*W-1:0] e;
    logic [W-1:0]   hold_hi, hold_lo;
    rst = 1; x_in = '0; y_in = '0; x_signed = 0; y_signed = 0; round_in = 0;
    idle(); fmt_full = 1; bypass = 0; upper_sel = 0; lo_oe_n = 1; hi_oe_n = 1;
    m_x = '0; m_y = '0; m_xs = 0; m_ys = 0; m_r = 0; m_phi = '0; m_plo = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset", hi_data, lo_data, '0, '0);
    rst = 0;

    // R4 / R5: four mode combinations, full format
    run_op("R4 uu R5", 16'hFFFF, 16'hFFFF, 0, 0, 0, 1);
    check("R4 uu value", hi_data, lo_data, 16'hFFFE, 16'h0001);
    run_op("R4 ss", 16'hFFFF, 16'hFFFF, 1, 1, 0, 1);
    check("R4 ss value", hi_data, lo_data, 16'h0000, 16'h0001);
    run_op("R4 su", 16'hFFFF, 16'h0002, 1, 0, 0, 1);
    check("R4 su value", hi_data, lo_data, 16'hFFFF, 16'hFFFE);
    run_op("R4 us", 16'h0003, 16'hFFFF, 0, 1, 0, 1);
    check("R4 us value", hi_data, lo_data, 16'hFFFF, 16'hFFFD);

    // R6: shifted format, 0.5 * 0.5 = 0.25 fractional
    run_op("R6 shift", 16'h4000, 16'h4000, 1, 1, 0, 0);
    check("R6 value", hi_data, lo_data, 16'h2000, 16'h0000);
    // R6: negative product repeats its sign in bit 15 of the lower half
    run_op("R6 sign copy", 16'hC000, 16'h4001, 1, 1, 0, 0);

    // R11: most-negative squared wraps
    run_op("R11 wrap", 16'h8000, 16'h8000, 1, 1, 0, 0);
    check("R11 value", hi_data, lo_data, 16'h8000, 16'h0000);

    // R7: rounding at bit 15 (full) carries into the upper half
    run_op("R7 full carry", 16'h0001, 16'h8000, 0, 0, 1, 1);
    check("R7 full value", hi_data, lo_data, 16'h0001, 16'h0000);
    // R7: rounding at bit 14 in shifted format
    run_op("R7 shifted", 16'h0001, 16'h4000, 0, 0, 1, 0);
    check("R7 shifted value", hi_data, lo_data, 16'h0001, 16'h0000);
    run_op("R7 no carry", 16'h0001, 16'h0001, 0, 0, 1, 1);
    check("R7 no carry value", hi_data, lo_data, 16'h0000, 16'h8001);

    // R3: new operands loaded while prod_load stays low leave outputs unchanged
    run_op("R3 setup", 16'h1234, 16'h5678, 0, 0, 0, 1);
    hold_hi = hi_data; hold_lo = lo_data;
    load_ops(16'h0F0F, 16'h0303, 1, 0, 1, 1, 1);
    @(negedge clk);
    check("R3 hold", hi_data, lo_data, hold_hi, hold_lo);
    cap_prod();
    check("R3 reload", hi_data, lo_data, m_phi, m_plo);

    // R1: y loads alone, x stalls at its old value
    load_ops(16'h7777, 16'h0005, 0, 0, 0, 0, 1);
    cap_prod();
    check("R1 x stalled", hi_data, lo_data, m_phi, m_plo);
    // R1: x loads alone
    load_ops(16'h0009, 16'hAAAA, 0, 1, 0, 1, 0);
    cap_prod();
    check("R1 y stalled", hi_data, lo_data, m_phi, m_plo);

    // R2: round captured with operands, ignored when no operand load
    fmt_full = 1;
    load_ops(16'h0001, 16'h0001, 0, 0, 1, 1, 1);
    @(negedge clk); round_in = 0;           // no load enables: must not reach round reg
    @(negedge clk);
    cap_prod();
    check("R2 round held", hi_data, lo_data, 16'h0000, 16'h8001);
    load_ops(16'h0000, 16'h0001, 0, 0, 0, 0, 1);  // y-only edge clears round
    cap_prod();
    check("R2 round via y_load", hi_data, lo_data, 16'h0000, 16'h0001);

    // R8: flow-through shows fresh operands without a product edge
    fmt_full = 0;
    load_ops(16'h2000, 16'hE000, 1, 1, 0, 1, 1);
    bypass = 1; #1;
    e = ref_prod(m_x, m_y, m_xs, m_ys, m_r, 0);
    check("R8 bypass", hi_data, lo_data, e[2*W-1:W], e[W-1:0]);
    fmt_full = 1; #1;
    e = ref_prod(m_x, m_y, m_xs, m_ys, m_r, 1);
    check("R8 bypass full", hi_data, lo_data, e[2*W-1:W], e[W-1:0]);
    bypass = 0; #1;
    check("R8 registers untouched", hi_data, lo_data, m_phi, m_plo);

    // R9: upper port selects the lower half
    upper_sel = 1; #1;
    check("R9 lower on upper port", hi_data, lo_data, m_plo, m_plo);
    upper_sel = 0; #1;

    // R10: drive flags follow the active-low enables
    for (int k = 0; k < 4; k++) begin
      lo_oe_n = k[0]; hi_oe_n = k[1]; #1;
      check("R10 drive", {15'd0, hi_drive}, {15'd0, lo_drive}, {15'd0, ~k[1]}, {15'd0, ~k[0]});
    end

    // random mix of modes, formats, rounding and bypass (R4 R5 R6 R7 R8)
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      logic as, bs, r, full, byp;
      a = W'($urandom); b = W'($urandom);
      if ($urandom_range(0, 7) == 0) a = 16'h8000;
      if ($urandom_range(0, 7) == 0) b = 16'hFFFF;
      as = 1'($urandom); bs = 1'($urandom); r = 1'($urandom);
      full = 1'($urandom); byp = 1'($urandom);
      fmt_full = full; bypass = 0;
      load_ops(a, b, as, bs, r, 1, 1);
      if (byp) begin
        bypass = 1; #1;
        e = ref_prod(m_x, m_y, m_xs, m_ys, m_r, full);
        check("R8 random bypass", hi_data, lo_data, e[2*W-1:W], e[W-1:0]);
        bypass = 0;
      end else begin
        cap_prod();
        check("R4 R5 R6 R7 random", hi_data, lo_data, m_phi, m_plo);
      end
    end

    // R12: reset mid-run clears everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R12 mid-run reset", hi_data, lo_data, '0, '0);
    bypass = 1; #1;
    check("R12 operands cleared", hi_data, lo_data, '0, '0);
    bypass = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule